// File: doc/BRIEF.md
# Keyed Single-Block SHA-1 Authenticator

This block produces a 160-bit SHA-1 digest of a challenge message joined to a secret key. The host presents a 160-bit message and a 128-bit key in parallel and pulses `start_i`. The block then builds the one 512-bit input block itself. The payload comes first, followed by a single 1 bit, zero fill, and a 64-bit length field that always holds 288. Because of this, the result equals a standard SHA-1 of the 288-bit string message‖key.

The hash runs one compression round per clock, 80 rounds in all. The working state is kept in registers and the sixteen-word message window rolls forward each cycle. When the block finishes it presents the digest and pulses `done_o` for one cycle. It has no multi-block messages, no variable lengths and no key storage. Those belong to the surrounding logic.

Top module: `sha1_keyed_auth`

## Requirements
- R1: The digest equals the standard SHA-1 of the 288-bit string formed by `msg_i` followed by `key_i`. Bit 159 of `msg_i` is the first bit of the block and big-endian word packing applies: word 0 is `msg_i[159:128]` and word 5 is `key_i[127:96]`. Word 9 is 0x80000000, words 10 to 14 are zero, and the 64-bit tail holds 0x120.
- R2: Every accepted start loads the standard initial chaining values, so a hash that begins in the same cycle `done_o` is high gives the same result as one started from an idle block.
- R3: `busy_o` goes high on the edge that accepts a start and stays high for exactly 80 cycles.
- R4: `done_o` is high for exactly one cycle. That cycle is the one in which `busy_o` has just fallen, and `digest_o` is already valid in it.
- R5: `digest_o` keeps its value from the done cycle until a later start completes.
- R6: A `start_i` pulse while `busy_o` is high has no effect on timing or result.
- R7: `msg_i` and `key_i` are captured on the accepting edge. Later changes to them do not alter the digest.
- R8: A synchronous active-low reset clears `busy_o`, `done_o` and `digest_o` on the next edge, including in the middle of a hash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a hash; accepted only when idle |
| msg_i | input | 160 | Challenge message, bit 159 first |
| key_i | input | 128 | Secret key, appended after the message |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse when the digest is ready |
| digest_o | output | 160 | Result, chaining word H0 in bits 159:128 |

## Verification
SHA-1 diffuses errors quickly. A wrong round function, constant, window tap, padding bit or initial value therefore changes almost every digest bit on the first `done_o`, 81 cycles after the start. A fault in the round counter or handshake shows up earlier, as a busy window that is not exactly 80 cycles or a done pulse that is missing, repeated or out of step with `busy_o`. Leakage of state from one hash into the next shows up only in a back-to-back start. Leakage from the live input pins shows up only when those pins are disturbed during the rounds. The stimulus therefore includes both cases.

// File: rtl/sha1_auth_pkg.sv
// Package: shared widths, types, initial chaining values and round helpers
// for the keyed single-block SHA-1 authenticator.
// Assumes the fixed payload of a 160-bit message plus a 128-bit key.
package sha1_auth_pkg;

    localparam int WORD_W     = 32;
    localparam int MSG_W      = 160;
    localparam int KEY_W      = 128;
    localparam int BLK_WORDS  = 16;
    localparam int BLK_BITS   = BLK_WORDS * WORD_W;
    localparam int LEN_W      = 64;
    localparam int DIG_WORDS  = 5;
    localparam int DIG_W      = DIG_WORDS * WORD_W;
    localparam int ROUNDS     = 80;
    localparam int RND_W      = $clog2(ROUNDS);
    localparam int PAYLOAD_W  = MSG_W + KEY_W;
    localparam int ZERO_FILL  = BLK_BITS - PAYLOAD_W - 1 - LEN_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RND_W-1:0]  rnd_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } state_t;

    localparam state_t INIT_STATE = '{
        a: 32'h67452301,
        b: 32'hEFCDAB89,
        c: 32'h98BADCFE,
        d: 32'h10325476,
        e: 32'hC3D2E1F0
    };

    localparam rnd_t PHASE1 = rnd_t'(20);
    localparam rnd_t PHASE2 = rnd_t'(40);
    localparam rnd_t PHASE3 = rnd_t'(60);

    // Rotate a word left by n bit places (0 < n < WORD_W).
    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Boolean mixing function chosen by the round's phase.
    function automatic word_t mix_f(input rnd_t r, input word_t b, input word_t c, input word_t d);
        if (r < PHASE1)      return (b & c) | (~b & d);
        else if (r < PHASE2) return b ^ c ^ d;
        else if (r < PHASE3) return (b & c) | (b & d) | (c & d);
        else                 return b ^ c ^ d;
    endfunction

    // Additive constant chosen by the round's phase.
    function automatic word_t phase_k(input rnd_t r);
        if (r < PHASE1)      return 32'h5A827999;
        else if (r < PHASE2) return 32'h6ED9EBA1;
        else if (r < PHASE3) return 32'h8F1BBCDC;
        else                 return 32'hCA62C1D6;
    endfunction

endpackage

// File: rtl/sha1_block_pack.sv
// Module: sha1_block_pack
// Purely combinational. Lays out the single 512-bit input block: the
// message, then the key, then a marker 1 bit, zero fill, and the 64-bit
// payload length. Assumes the payload length is fixed by the package.
module sha1_block_pack
    import sha1_auth_pkg::*;
(
    input  logic [MSG_W-1:0]    msg_i,
    input  logic [KEY_W-1:0]    key_i,
    output logic [BLK_BITS-1:0] blk_o
);

    localparam logic [LEN_W-1:0] LEN_FIELD = LEN_W'(PAYLOAD_W);

    // Assemble the padded block; bit BLK_BITS-1 is the first bit hashed.
    assign blk_o = {msg_i, key_i, 1'b1, {ZERO_FILL{1'b0}}, LEN_FIELD};

endmodule

// File: rtl/sha1_msg_sched.sv
// Module: sha1_msg_sched
// Sixteen-word rolling message window. On load it takes the block's words
// in order; on each step it shifts by one word and appends the next
// expanded word. w_o is always the word for the round being computed.
// Assumes load and step are never both high.
module sha1_msg_sched
    import sha1_auth_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic [BLK_BITS-1:0] blk_i,
    output word_t               w_o
);

    word_t win_q   [BLK_WORDS];
    word_t load_w  [BLK_WORDS];
    word_t shift_w [BLK_WORDS];
    word_t feed_w;

    // Expansion word: taps 3, 8, 14 and 16 positions back, rotated by one.
    assign feed_w = rotl(win_q[BLK_WORDS-3] ^ win_q[BLK_WORDS-8] ^
                         win_q[BLK_WORDS-14] ^ win_q[0], 1);

    for (genvar i = 0; i < BLK_WORDS; i++) begin : g_win
        assign load_w[i] = blk_i[BLK_BITS-1-WORD_W*i -: WORD_W];
        if (i == BLK_WORDS-1) begin : g_tail
            assign shift_w[i] = feed_w;
        end else begin : g_body
            assign shift_w[i] = win_q[i+1];
        end
    end

    // Window register: load a fresh block or roll one word forward.
    always_ff @(posedge clk) begin
        if (load_i) begin
            win_q <= load_w;
        end else if (step_i) begin
            win_q <= shift_w;
        end
    end

    assign w_o = win_q[0];

    AST_WIN_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> w_o == $past(blk_i[BLK_BITS-1 -: WORD_W])); // R1

    AST_WIN_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> w_o == $past(win_q[1])); // R1

endmodule

// File: rtl/sha1_round_core.sv
// Module: sha1_round_core
// Holds the five working words. Load sets them to the initial chaining
// values; each step applies one compression round using the current
// schedule word and round index. nxt_o exposes the post-round state so the
// caller can form the digest in the same edge as the last round.
module sha1_round_core
    import sha1_auth_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  logic   step_i,
    input  rnd_t   rnd_i,
    input  word_t  w_i,
    output state_t nxt_o
);

    state_t vars_q;
    word_t  sum_w;

    // One round: new a from the phase function, constant and schedule word.
    always_comb begin
        sum_w = rotl(vars_q.a, 5) + mix_f(rnd_i, vars_q.b, vars_q.c, vars_q.d)
              + vars_q.e + phase_k(rnd_i) + w_i;
        nxt_o = '{a: sum_w, b: vars_q.a, c: rotl(vars_q.b, 30), d: vars_q.c, e: vars_q.d};
    end

    // Working-state register: seed with chaining values or advance a round.
    always_ff @(posedge clk) begin
        if (load_i) begin
            vars_q <= INIT_STATE;
        end else if (step_i) begin
            vars_q <= nxt_o;
        end
    end

    AST_SEED_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> vars_q == INIT_STATE); // R2

    AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (vars_q.b == $past(vars_q.a)) && (vars_q.e == $past(vars_q.d))); // R1

endmodule

// File: rtl/sha1_seq_ctrl.sv
// Module: sha1_seq_ctrl
// Round sequencer. Accepts a start only when idle, then counts ROUNDS
// steps. On the final step it drops busy and raises a one-cycle done.
// Assumes ROUNDS >= 2.
module sha1_seq_ctrl
    import sha1_auth_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output rnd_t rnd_o,
    output logic busy_o,
    output logic done_o
);

    localparam rnd_t LAST_RND = rnd_t'(ROUNDS - 1);

    logic busy_q;
    logic done_q;
    rnd_t rnd_q;

    // Accept only when idle; a start during a run is dropped.
    assign load_o = start_i && !busy_q;
    assign step_o = busy_q;
    assign last_o = busy_q && (rnd_q == LAST_RND);
    assign rnd_o  = rnd_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // Sequencer state: idle/busy flag, round index and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rnd_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                rnd_q  <= '0;
            end else if (busy_q) begin
                if (rnd_q == LAST_RND) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    rnd_q  <= '0;
                end else begin
                    rnd_q <= rnd_q + rnd_t'(1);
                end
            end
        end
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && rnd_q == '0)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R4

    AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && rnd_q != LAST_RND) |=> (busy_o && rnd_q == $past(rnd_q) + rnd_t'(1))); // R6

    AST_ROUND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> rnd_q <= LAST_RND); // R3

endmodule

// File: rtl/sha1_keyed_auth.sv
// Module: sha1_keyed_auth (top)
// Keyed single-block SHA-1. Captures message and key on an accepted start,
// runs one round per cycle, then adds the final working state to the
// initial chaining values and holds the digest until the next completion.
// Assumes a synchronous active-low reset.
module sha1_keyed_auth
    import sha1_auth_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [MSG_W-1:0] msg_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [DIG_W-1:0] digest_o
);

    logic [BLK_BITS-1:0] blk_w;
    logic                load_w;
    logic                step_w;
    logic                last_w;
    rnd_t                rnd_w;
    word_t               sched_w;
    state_t              nxt_w;
    logic [DIG_W-1:0]    digest_q;
    logic [DIG_W-1:0]    digest_d;

    sha1_block_pack u_pack (
        .msg_i (msg_i),
        .key_i (key_i),
        .blk_o (blk_w)
    );

    sha1_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load_w),
        .step_o  (step_w),
        .last_o  (last_w),
        .rnd_o   (rnd_w),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    sha1_msg_sched u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .step_i (step_w),
        .blk_i  (blk_w),
        .w_o    (sched_w)
    );

    sha1_round_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .step_i (step_w),
        .rnd_i  (rnd_w),
        .w_i    (sched_w),
        .nxt_o  (nxt_w)
    );

    // Feed-forward addition of the last round's state to the chaining values.
    assign digest_d = {INIT_STATE.a + nxt_w.a,
                       INIT_STATE.b + nxt_w.b,
                       INIT_STATE.c + nxt_w.c,
                       INIT_STATE.d + nxt_w.d,
                       INIT_STATE.e + nxt_w.e};

    // Digest register: cleared by reset, written only on the final round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digest_q <= '0;
        end else if (last_w) begin
            digest_q <= digest_d;
        end
    end

    assign digest_o = digest_q;

    AST_DIGEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(digest_o)) |-> done_o); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && digest_o == '0)); // R8

    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o); // R4

endmodule

// File: tb/sha1_keyed_auth_bench.sv
// Bench for sha1_keyed_auth: directed corner cases plus seeded random
// payloads, all compared with a reference SHA-1 computed in the bench.
module sha1_keyed_auth_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [159:0] msg_i = '0;
    logic [127:0] key_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [159:0] digest_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sha1_keyed_auth u_sha1_keyed_auth (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .msg_i    (msg_i),
        .key_i    (key_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .digest_o (digest_o)
    );

    function automatic logic [31:0] rol(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // Reference SHA-1 of the 288-bit payload m||k, with a full 80-word expansion.
    function automatic logic [159:0] ref_sha(input logic [159:0] m, input logic [127:0] k);
        logic [511:0] blk;
        logic [31:0]  w [80];
        logic [31:0]  h [5];
        logic [31:0]  a, b, c, d, e, f, kc, t;
        blk = {m, k, 1'b1, 159'd0, 64'd288};
        for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rol(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        h[0] = 32'h67452301; h[1] = 32'hEFCDAB89; h[2] = 32'h98BADCFE;
        h[3] = 32'h10325476; h[4] = 32'hC3D2E1F0;
        a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          kc = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   kc = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); kc = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   kc = 32'hCA62C1D6; end
            t = rol(a, 5) + f + e + kc + w[i];
            e = d; d = c; c = rol(b, 30); b = a; a = t;
        end
        return {h[0] + a, h[1] + b, h[2] + c, h[3] + d, h[4] + e};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [159:0] rnd160();
        return {$urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Run one hash. mode 0: quiet inputs; 1: scramble inputs while busy (R7);
    // 2: extra start with other data mid-run (R6). Leaves the bench in the done cycle.
    task automatic run_hash(input logic [159:0] m, input logic [127:0] k, input int mode);
        int cyc;
        logic [159:0] exp;
        exp = ref_sha(m, k);
        msg_i = m; key_i = k; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R3", "busy after start", 160'(busy_o), 160'd1);
        cyc = 0;
        while (busy_o === 1'b1 && cyc < 200) begin
            cyc++;
            if (mode == 1) begin msg_i = rnd160(); key_i = rnd128(); end
            if (mode == 2) begin
                start_i = (cyc == 30);
                if (cyc == 30) begin msg_i = ~m; key_i = ~k; end
            end
            if (done_o !== 1'b0) chk(1'b0, "R4", "done during busy", 160'(done_o), 160'd0);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(cyc == 80, "R3", "busy length", 160'(cyc), 160'd80);
        chk(done_o === 1'b1, "R4", "done at end", 160'(done_o), 160'd1);
        if (mode == 1)      chk(digest_o === exp, "R7", "digest with moving inputs", digest_o, exp);
        else if (mode == 2) chk(digest_o === exp, "R6", "digest with ignored start", digest_o, exp);
        else                chk(digest_o === exp, "R1", "digest", digest_o, exp);
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "WATCHDOG", "timeout", '0, '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [159:0] m0;
        logic [127:0] k0;
        logic [159:0] held;
        void'($urandom(32'h1D5EED));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(busy_o === 1'b0, "R8", "busy in reset", 160'(busy_o), 160'd0);
        chk(done_o === 1'b0, "R8", "done in reset", 160'(done_o), 160'd0);
        chk(digest_o === '0, "R8", "digest in reset", digest_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: directed corner payloads
        run_hash('0, '0, 0);
        @(negedge clk);
        run_hash('1, '1, 0);
        @(negedge clk);
        run_hash({32'h80000000, 128'd0}, 128'd1, 0);
        held = digest_o;
        // R5: digest held and done drops while idle
        @(negedge clk);
        chk(done_o === 1'b0, "R4", "done single cycle", 160'(done_o), 160'd0);
        msg_i = rnd160(); key_i = rnd128();
        repeat (5) @(negedge clk);
        chk(digest_o === held, "R5", "digest held while idle", digest_o, held);

        // R5: digest held through a running hash until its completion
        m0 = rnd160(); k0 = rnd128();
        msg_i = m0; key_i = k0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(digest_o === held, "R5", "digest held mid-run", digest_o, held);
        while (busy_o === 1'b1) @(negedge clk);
        chk(digest_o === ref_sha(m0, k0), "R1", "digest after hold test", digest_o, ref_sha(m0, k0));

        // R2: back-to-back start in the done cycle
        m0 = rnd160(); k0 = rnd128();
        run_hash(m0, k0, 0);
        run_hash(~m0, k0, 0);
        chk(digest_o === ref_sha(~m0, k0), "R2", "back-to-back digest", digest_o, ref_sha(~m0, k0));
        @(negedge clk);

        // R7 and R6
        run_hash(rnd160(), rnd128(), 1);
        @(negedge clk);
        run_hash(rnd160(), rnd128(), 2);
        @(negedge clk);

        // R8: reset in the middle of a hash
        msg_i = rnd160(); key_i = rnd128(); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy_o === 1'b0, "R8", "busy cleared mid-run", 160'(busy_o), 160'd0);
        chk(done_o === 1'b0, "R8", "done cleared mid-run", 160'(done_o), 160'd0);
        chk(digest_o === '0, "R8", "digest cleared mid-run", digest_o, '0);
        repeat (100) @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R8", "no completion after reset",
            {busy_o, done_o}, '0);

        // R1: seeded random payloads, some back-to-back
        for (int i = 0; i < 12; i++) begin
            run_hash(rnd160(), rnd128(), 0);
            if (i % 3 == 0) @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule